// File: doc/BRIEF.md
# Event-Driven Timer with Capture Channels

This block is a 16-bit timer whose count reacts to an 8-line event bus. A control word picks an event line and an action. The actions are: do nothing, input capture, counting up or down under the control of a line level, quadrature decoding, restarting the count, frequency capture and pulse-width capture. In input capture each of the four channels takes its own line. Channel A uses the selected line and channels B, C and D use the next three lines, wrapping past line 7. Each channel keeps its captured counts in a two-entry queue: the visible capture register plus a one-deep buffer behind it. A capture that arrives when both entries are full is dropped and raises a sticky error flag.

A single write port loads the control word, the period, the count, and the error-clear mask. An optional one-cycle delay on the event path lines up events that come from a neighbouring counter's carry, so two units can be chained for a 32-bit capture. The selected line levels drive a four-state phase machine that keeps the previous level of lines A and B. Its states are PH_00, PH_01, PH_10 and PH_11, named after the bits {A,B}. From any state the machine moves to the state given by the present levels. For quadrature counting, a transition is called forward when it follows the order PH_00→PH_10→PH_11→PH_01→PH_00, and backward when it follows the reverse order. A hold keeps the same state. A jump moves to the diagonal state and does not count. Pulse-width mode uses the same states to find the edges of line A.

Top module: `evcap_timer`

## Requirements
- R1: After reset the action is 0 (none), the delay is off, the select is 0, the count is 0, the period is 0xFFFF, and every capture flag and error flag is 0.
- R2: With action 000 (none) or 111 (reserved), the count rises by one per cycle. After reaching the period value it returns to 0. Events have no effect.
- R3: With action 001 (input capture) and select value n, channel k (A=0 … D=3) takes line (n+k) mod 8. A high level on that line at a clock edge loads the count held before that edge into the channel, and the count keeps running as in R2.
- R4: Each channel queues up to two captures. cap_flag shows that the head entry is valid and cap_data shows the head. Pulsing cap_pop advances the queue. A capture that arrives while both entries are full is lost and sets cap_err. cap_err is cleared by writing a 1 to that bit of register address 2, but a new overflow in the same cycle wins.
- R5: Control bit 4 (delay) set: the timer acts on each event line one clock later than it would with the bit clear.
- R6: With action 010 (up/down), the count decreases while line A is high and increases while it is low. It wraps from 0 to the period value and from the period value to 0.
- R7: With action 011 (quadrature), line A and the next line B form a phase pair {A,B}. A forward transition increments the count and a backward transition decrements it, with the same wrap as R6. A hold or a jump leaves the count unchanged.
- R8: With action 100 (restart), a high level on line A clears the count to 0. Otherwise the count runs as in R2.
- R9: With action 101 (frequency), a high level on line A loads the count into channel A and clears the count.
- R10: With action 110 (pulse width), a rising edge of line A clears the count and a falling edge loads the count into channel A.
- R11: Write addresses are: 0 control (action in bits 7:5, delay in bit 4, select in bits 3:0), 1 period, 2 error clear, 3 count load. Bit 3 of the select field is ignored. A count load wins over every action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 period, 2 error clear, 3 count) |
| wr_data | input | 16 | Write data |
| ev_bus | input | 8 | Event lines |
| cap_pop | input | 4 | Per-channel pop of the head capture entry |
| count | output | 16 | Current count |
| cap_flag | output | 4 | Head capture entry valid, per channel |
| cap_err | output | 4 | Sticky capture overflow, per channel |
| cap_data | output | 64 | Head capture value, channel k in bits 16k+15:16k |

## Verification
The bench targets four kinds of corner case.

- Select wrap: the channel lines are checked with a select value whose channels wrap past line 7 and with bit 3 set. A design that added without wrapping, or decoded bit 3, would feed channels from the wrong lines.
- Queue limits: the capture queue is driven into overflow, and pops are made in the same cycle as captures. A design that overwrote the buffered entry, or let a clear beat an overflow, would show wrong data or a missing error.
- Wrap points: the count is held at the period value and at zero in up/down and quadrature modes. An off-by-one there would give period+1 or fail to wrap.
- Edge timing: pulse-width and delayed-event timing are compared cycle by cycle, so a design that acted one cycle early or late shows a mismatched count.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,
        ACT_CAPT    = 3'd1,
        ACT_UPDN    = 3'd2,
        ACT_QDEC    = 3'd3,
        ACT_RESTART = 3'd4,
        ACT_FRQ     = 3'd5,
        ACT_PW      = 3'd6,
        ACT_RSVD    = 3'd7
    } act_e;

    // previous levels of lines {A,B}
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } phase_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_PER  = 2'd1;
    localparam logic [1:0] ADDR_ECLR = 2'd2;
    localparam logic [1:0] ADDR_CNT  = 2'd3;
endpackage

// File: rtl/evcap_route.sv
module evcap_route #(
    parameter int LINES = 8,
    parameter int CH    = 4,
    parameter int SELW  = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] bus,
    input  logic             dly,
    input  logic [SELW-1:0]  sel,
    output logic [CH-1:0]    ch_ev
);
    logic [LINES-1:0] bus_d;
    logic [LINES-1:0] src;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_d <= '0;
        else        bus_d <= bus;
    end

    assign src = dly ? bus_d : bus;

    for (genvar k = 0; k < CH; k++) begin : g_ch
        logic [SELW-1:0] idx;
        assign idx      = sel + SELW'(k);
        assign ch_ev[k] = src[idx];
    end
endmodule

// File: rtl/evcap_chan.sv
module evcap_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_stb,
    input  logic [W-1:0] cap_val,
    input  logic         pop,
    input  logic         err_clr,
    output logic [W-1:0] head,
    output logic         valid,
    output logic         err
);
    logic [W-1:0] buf_q, buf_n, head_n, head_p;
    logic         buf_v, buf_vn, buf_vp, valid_n, valid_p, ovf;

    always_comb begin
        if (pop && valid) begin
            head_p  = buf_q;
            valid_p = buf_v;
            buf_vp  = 1'b0;
        end else begin
            head_p  = head;
            valid_p = valid;
            buf_vp  = buf_v;
        end
        head_n  = head_p;
        valid_n = valid_p;
        buf_n   = buf_q;
        buf_vn  = buf_vp;
        ovf     = 1'b0;
        if (cap_stb) begin
            if (!valid_p) begin
                head_n  = cap_val;
                valid_n = 1'b1;
            end else if (!buf_vp) begin
                buf_n  = cap_val;
                buf_vn = 1'b1;
            end else begin
                ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head  <= '0;
            valid <= 1'b0;
            buf_q <= '0;
            buf_v <= 1'b0;
            err   <= 1'b0;
        end else begin
            head  <= head_n;
            valid <= valid_n;
            buf_q <= buf_n;
            buf_v <= buf_vn;
            if (ovf)          err <= 1'b1;
            else if (err_clr) err <= 1'b0;
        end
    end

    // R4
    err_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(valid && buf_v && cap_stb));

    // R4
    buf_behind_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_v |-> valid);

    // R4
    pop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && buf_v) |=> valid);
endmodule

// File: rtl/evcap_timer.sv
module evcap_timer
    import evcap_pkg::*;
#(
    parameter int W     = 16,
    parameter int LINES = 8,
    parameter int CH    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [W-1:0]    wr_data,
    input  logic [LINES-1:0] ev_bus,
    input  logic [CH-1:0]   cap_pop,
    output logic [W-1:0]    count,
    output logic [CH-1:0]   cap_flag,
    output logic [CH-1:0]   cap_err,
    output logic [CH*W-1:0] cap_data
);
    localparam int SELW = $clog2(LINES);

    act_e            act_q;
    logic            dly_q;
    logic [SELW-1:0] sel_q;
    logic [W-1:0]    period;
    phase_e          phase_q;

    logic [CH-1:0]   ch_ev;
    logic [CH-1:0]   cap_stb;
    logic [CH-1:0]   err_clr;
    logic [W-1:0]    cnt_n, cnt_inc, cnt_dec;
    logic [1:0]      ph_prev, ph_cur;
    logic            ev_a, q_up, q_dn, pw_rise, pw_fall, cnt_wr;

    evcap_route #(.LINES(LINES), .CH(CH), .SELW(SELW)) u_route (
        .clk(clk), .rst_n(rst_n), .bus(ev_bus), .dly(dly_q), .sel(sel_q), .ch_ev(ch_ev)
    );

    assign ev_a    = ch_ev[0];
    assign ph_cur  = {ch_ev[0], ch_ev[1]};
    assign ph_prev = phase_q;
    assign pw_rise = ev_a && !ph_prev[1];
    assign pw_fall = !ev_a && ph_prev[1];
    assign cnt_wr  = wr_en && (wr_addr == ADDR_CNT);
    assign err_clr = (wr_en && wr_addr == ADDR_ECLR) ? wr_data[CH-1:0] : '0;
    assign cnt_inc = (count == period) ? '0 : count + 1'b1;
    assign cnt_dec = (count == '0) ? period : count - 1'b1;

    // state register: control, period, count, phase machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q   <= ACT_NONE;
            dly_q   <= 1'b0;
            sel_q   <= '0;
            period  <= '1;
            count   <= '0;
            phase_q <= PH_00;
        end else begin
            phase_q <= phase_e'(ph_cur);
            count   <= cnt_wr ? wr_data : cnt_n;
            if (wr_en && wr_addr == ADDR_CTRL) begin
                act_q <= act_e'(wr_data[7:5]);
                dly_q <= wr_data[4];
                sel_q <= wr_data[SELW-1:0];
            end
            if (wr_en && wr_addr == ADDR_PER) period <= wr_data;
        end
    end

    // quadrature transition decode
    always_comb begin
        q_up = 1'b0;
        q_dn = 1'b0;
        unique case (phase_q)
            PH_00: begin q_up = (ph_cur == 2'b10); q_dn = (ph_cur == 2'b01); end
            PH_10: begin q_up = (ph_cur == 2'b11); q_dn = (ph_cur == 2'b00); end
            PH_11: begin q_up = (ph_cur == 2'b01); q_dn = (ph_cur == 2'b10); end
            PH_01: begin q_up = (ph_cur == 2'b00); q_dn = (ph_cur == 2'b11); end
        endcase
    end

    // outputs of the action decode: next count and capture strobes
    always_comb begin
        cnt_n   = cnt_inc;
        cap_stb = '0;
        unique case (act_q)
            ACT_CAPT:    cap_stb = ch_ev;
            ACT_UPDN:    cnt_n = ev_a ? cnt_dec : cnt_inc;
            ACT_QDEC:    cnt_n = q_up ? cnt_inc : (q_dn ? cnt_dec : count);
            ACT_RESTART: cnt_n = ev_a ? '0 : cnt_inc;
            ACT_FRQ: begin
                cnt_n      = ev_a ? '0 : cnt_inc;
                cap_stb[0] = ev_a;
            end
            ACT_PW: begin
                cnt_n      = pw_rise ? '0 : cnt_inc;
                cap_stb[0] = pw_fall;
            end
            default:     cnt_n = cnt_inc;
        endcase
    end

    for (genvar k = 0; k < CH; k++) begin : g_chan
        evcap_chan #(.W(W)) u_chan (
            .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb[k]), .cap_val(count),
            .pop(cap_pop[k]), .err_clr(err_clr[k]),
            .head(cap_data[k*W +: W]), .valid(cap_flag[k]), .err(cap_err[k])
        );
    end

    // R8
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == ACT_RESTART && ch_ev[0] && !cnt_wr) |=> (count == '0));

    // R9
    frq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == ACT_FRQ && ch_ev[0] && !cnt_wr) |=> (count == '0 && cap_flag[0]));

    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_q == ACT_NONE || act_q == ACT_RSVD) && count == period && !cnt_wr)
        |=> (count == '0));

    // R6
    updn_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == ACT_UPDN && ch_ev[0] && count != '0 && !cnt_wr)
        |=> (count == $past(count) - 1'b1));
endmodule

// File: tb/evcap_timer_bench.sv
`timescale 1ns/1ps
module evcap_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [7:0]  ev_bus = 8'd0;
    logic [3:0]  cap_pop = 4'd0;
    logic [15:0] count;
    logic [3:0]  cap_flag, cap_err;
    logic [63:0] cap_data;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    evcap_timer u_evcap_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ev_bus(ev_bus), .cap_pop(cap_pop), .count(count), .cap_flag(cap_flag),
        .cap_err(cap_err), .cap_data(cap_data)
    );

    // reference model state
    logic [2:0]  m_act;
    logic        m_dly;
    logic [2:0]  m_sel;
    logic [15:0] m_per, m_cnt;
    logic [7:0]  m_busd;
    logic        m_pa, m_pb;
    logic [15:0] m_head [4];
    logic [15:0] m_buf  [4];
    int          m_occ  [4];
    logic [3:0]  m_err;

    function automatic logic [1:0] qnext(input logic [1:0] p);
        case (p)
            2'b00:   return 2'b10;
            2'b10:   return 2'b11;
            2'b11:   return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [15:0] inc_w(input logic [15:0] c, input logic [15:0] p);
        return (c == p) ? 16'd0 : c + 16'd1;
    endfunction

    function automatic logic [15:0] dec_w(input logic [15:0] c, input logic [15:0] p);
        return (c == 16'd0) ? p : c - 16'd1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_act = 3'd0; m_dly = 1'b0; m_sel = 3'd0; m_per = 16'hFFFF; m_cnt = 16'd0;
            m_busd = 8'd0; m_pa = 1'b0; m_pb = 1'b0; m_err = 4'd0;
            for (int k = 0; k < 4; k++) begin m_head[k] = 16'd0; m_buf[k] = 16'd0; m_occ[k] = 0; end
        end else begin : mstep
            logic [7:0]  src;
            logic [3:0]  e, stb;
            logic [15:0] nc;
            logic [1:0]  pv, cv;
            src = m_dly ? m_busd : ev_bus;
            for (int k = 0; k < 4; k++) e[k] = src[(int'(m_sel) + k) % 8];
            pv = {m_pa, m_pb};
            cv = {e[0], e[1]};
            stb = 4'd0;
            nc = inc_w(m_cnt, m_per);
            case (m_act)
                3'd1: stb = e;
                3'd2: nc = e[0] ? dec_w(m_cnt, m_per) : inc_w(m_cnt, m_per);
                3'd3: nc = (cv == qnext(pv)) ? inc_w(m_cnt, m_per) :
                           (pv == qnext(cv)) ? dec_w(m_cnt, m_per) : m_cnt;
                3'd4: nc = e[0] ? 16'd0 : nc;
                3'd5: begin nc = e[0] ? 16'd0 : nc; stb[0] = e[0]; end
                3'd6: begin nc = (e[0] && !m_pa) ? 16'd0 : nc; stb[0] = !e[0] && m_pa; end
                default: ;
            endcase
            for (int k = 0; k < 4; k++) begin
                if (cap_pop[k] && m_occ[k] > 0) begin
                    m_head[k] = m_buf[k];
                    m_occ[k]  = m_occ[k] - 1;
                end
                if (wr_en && wr_addr == 2'd2 && wr_data[k]) m_err[k] = 1'b0;
                if (stb[k]) begin
                    if (m_occ[k] == 0)      begin m_head[k] = m_cnt; m_occ[k] = 1; end
                    else if (m_occ[k] == 1) begin m_buf[k]  = m_cnt; m_occ[k] = 2; end
                    else                    m_err[k] = 1'b1;
                end
            end
            if (wr_en && wr_addr == 2'd3) nc = wr_data;
            if (wr_en && wr_addr == 2'd0) begin
                m_act = wr_data[7:5]; m_dly = wr_data[4]; m_sel = wr_data[2:0];
            end
            if (wr_en && wr_addr == 2'd1) m_per = wr_data;
            m_cnt  = nc;
            m_busd = ev_bus;
            m_pa   = e[0];
            m_pb   = e[1];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, 32'(count), 32'(m_cnt));
        for (int k = 0; k < 4; k++) begin
            check(tag, 32'(cap_flag[k]), 32'(m_occ[k] > 0));
            check("R4", 32'(cap_err[k]), 32'(m_err[k]));
            if (m_occ[k] > 0) check(tag, 32'(cap_data[k*16 +: 16]), 32'(m_head[k]));
        end
    endtask

    task automatic step(input logic we, input logic [1:0] a, input logic [15:0] d,
                        input logic [7:0] bus, input logic [3:0] pop, input string tag);
        wr_en = we; wr_addr = a; wr_data = d; ev_bus = bus; cap_pop = pop;
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    // kind: 0 sparse pulses, 1 held levels, 2 quadrature, 3 pulse train
    task automatic run_phase(input logic [2:0] act, input logic dly, input logic [3:0] sel,
                             input logic [15:0] per, input int n, input int kind, input string tag);
        logic [7:0] bus = 8'd0;
        logic [1:0] g = 2'b00;
        logic       la = 1'b0;
        int         s = int'(sel[2:0]);
        step(1'b1, 2'd1, per, 8'd0, 4'hF, tag);
        step(1'b1, 2'd3, 16'd0, 8'd0, 4'hF, tag);
        step(1'b1, 2'd0, {8'd0, act, dly, sel}, 8'd0, 4'hF, tag);
        for (int i = 0; i < n; i++) begin
            logic       we = 1'b0;
            logic [1:0] a = 2'd0;
            logic [15:0] d = 16'd0;
            logic [3:0] pop = 4'd0;
            case (kind)
                0: for (int b = 0; b < 8; b++) bus[b] = ($urandom % 4 == 0);
                1: if (i % 7 == 0) bus = 8'($urandom);
                2: begin
                    case ($urandom % 3)
                        0: g = g + 2'd1;
                        1: g = g - 2'd1;
                        default: ;
                    endcase
                    bus = 8'($urandom);
                    bus[s]           = (g == 2'd1 || g == 2'd2);
                    bus[(s + 1) % 8] = (g == 2'd2 || g == 2'd3);
                end
                default: begin
                    if ($urandom % 8 == 0) la = ~la;
                    bus = 8'($urandom);
                    bus[s] = la;
                end
            endcase
            for (int k = 0; k < 4; k++) pop[k] = ($urandom % 3 == 0);
            if ($urandom % 20 == 0) begin we = 1'b1; a = 2'd2; d = 16'($urandom % 16); end
            step(we, a, d, bus, pop, tag);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", 32'(count), 32'd0);
        check("R1", 32'(cap_flag), 32'd0);
        check("R1", 32'(cap_err), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'(count), 32'd1);  // period 0xFFFF, action none

        run_phase(3'd0, 1'b0, 4'd2, 16'd37, 150, 0, "R2");
        run_phase(3'd7, 1'b0, 4'd5, 16'd20, 120, 0, "R2");
        run_phase(3'd1, 1'b0, 4'd6, 16'd300, 400, 0, "R3");
        run_phase(3'd1, 1'b1, 4'd3, 16'd250, 400, 0, "R5");
        run_phase(3'd2, 1'b0, 4'd4, 16'd25, 300, 1, "R6");
        run_phase(3'd3, 1'b0, 4'd7, 16'd9, 400, 2, "R7");
        run_phase(3'd4, 1'b0, 4'd1, 16'd200, 250, 0, "R8");
        run_phase(3'd5, 1'b0, 4'd0, 16'd500, 300, 0, "R9");
        run_phase(3'd6, 1'b0, 4'd3, 16'd900, 400, 3, "R10");
        run_phase(3'd1, 1'b0, 4'b1101, 16'd400, 300, 0, "R11");

        // R4 directed: three captures with no pop overflow channel A
        step(1'b1, 2'd0, 16'h0020, 8'd0, 4'hF, "R4");
        repeat (3) step(1'b0, 2'd0, 16'd0, 8'd0, 4'hF, "R4");
        step(1'b1, 2'd2, 16'h000F, 8'd0, 4'h0, "R4");
        repeat (3) step(1'b0, 2'd0, 16'd0, 8'h01, 4'h0, "R4");
        step(1'b0, 2'd0, 16'd0, 8'd0, 4'h0, "R4");
        check("R4", 32'(cap_err[0]), 32'd1);
        check("R4", 32'(cap_flag[0]), 32'd1);
        // clear races a new overflow: overflow wins
        step(1'b1, 2'd2, 16'h0001, 8'h01, 4'h0, "R4");
        check("R4", 32'(cap_err[0]), 32'd1);
        step(1'b1, 2'd2, 16'h0001, 8'h00, 4'h0, "R4");
        check("R4", 32'(cap_err[0]), 32'd0);

        // R11 count load wins over restart
        step(1'b1, 2'd0, 16'h0080, 8'd0, 4'h0, "R11");
        step(1'b1, 2'd3, 16'h1234, 8'h01, 4'h0, "R11");
        check("R11", 32'(count), 32'h1234);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule